// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block sits beside the transmit and receive FIFOs of a serial controller and turns their fill levels and error events into one interrupt line. Two level conditions are compared against programmable thresholds: the transmit side asks for more data when its occupancy has fallen to the threshold, and the receive side asks to be drained once its occupancy exceeds the threshold. Overflow and underflow events, and the end of a slave-select window, are captured as sticky bits that stay set until software removes them by writing a clear register. Each bit can be removed on its own, or all of them together.

Software reaches the block through a small register port: a write strobe with address and data, and a read path whose data follows the address in the same cycle. A mask register selects which raw bits reach the interrupt line. A separate 6-bit status word collects the busy and FIFO flags for software polling.

Top module: `fifo_thresh_irq`

## Requirements
- R1: After a synchronous active-low reset both thresholds and the mask read as 0, all sticky bits are 0 and `irq` is 0.
- R2: Raw bit 0 (transmit wants data) is 1 exactly while the transmit level is less than or equal to the transmit threshold. It follows the level in the same cycle and is not sticky.
- R3: Raw bit 4 (receive wants draining) is 1 exactly while the receive level is at least the receive threshold plus one.
- R4: A transmit push while the transmit FIFO is full sets raw bit 1. A receive pop while the receive FIFO is empty sets raw bit 2. A receive push while the receive FIFO is full sets raw bit 3. A slave-select-inactive pulse sets raw bit 6. Each bit shows from the cycle after the event and stays set after the event ends. Raw bit 5 always reads 0.
- R5: Writing the clear register (address 5) with data bit 1 clears raw bit 2, data bit 2 clears raw bit 3, and data bit 3 clears raw bit 1. Data bit 0 clears raw bits 1, 2, 3 and 6 together. Other sticky bits keep their values.
- R6: If an event arrives in the same cycle as a clear write for its bit, the bit stays set.
- R7: The masked status (address 4) equals the raw status (address 3) ANDed with the mask (address 2). `irq` is 1 exactly when any masked bit is 1.
- R8: While `ctrl_en` is 1, writes to the transmit threshold (address 0) and the receive threshold (address 1) are ignored. While `ctrl_en` is 0 they take effect.
- R9: `status` carries bit 0 busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full and bit 5 slave transmit busy, taken from the matching inputs.
- R10: Address 6 reads the transmit FIFO occupancy and address 7 reads the receive FIFO occupancy, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enabled; locks the thresholds |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_full | input | 1 | Transmit FIFO full flag |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| ss_inactive | input | 1 | Slave-select-inactive event pulse |
| eng_busy | input | 1 | Serial engine busy |
| slv_tx_busy | input | 1 | Slave transmit busy |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Interrupt line |
| status | output | 6 | Status word |

## Verification
A sticky bit that loses its value shows as a 0 in the raw read and a dropped `irq` in the cycle after the event ends. A clear that reaches the wrong bit shows in the read that follows the clear write. A threshold that is wrongly stored, compared with the wrong operator, or unlocked while enabled flips raw bit 0 or bit 4 in the same cycle that a level sits on the threshold. The bench therefore drives levels exactly at the threshold and one step past it.

// File: rtl/fti_pkg.sv
// Shared constants for the FIFO threshold interrupt controller.
// Assumes a 3-bit register address space and a 7-bit interrupt vector.
package fti_pkg;
    localparam int IRQ_W  = 7;
    localparam int IB_TXE = 0;   // transmit level at or below threshold
    localparam int IB_TXO = 1;   // transmit overflow, sticky
    localparam int IB_RXU = 2;   // receive underflow, sticky
    localparam int IB_RXO = 3;   // receive overflow, sticky
    localparam int IB_RXF = 4;   // receive level above threshold
    localparam int IB_SSI = 6;   // slave-select inactive, sticky

    localparam int CB_ALL = 0;
    localparam int CB_RXU = 1;
    localparam int CB_RXO = 2;
    localparam int CB_TXO = 3;

    localparam int N_STICKY = 4;

    typedef enum logic [2:0] {
        A_TXTHR = 3'd0,
        A_RXTHR = 3'd1,
        A_MASK  = 3'd2,
        A_RAW   = 3'd3,
        A_MSKD  = 3'd4,
        A_CLR   = 3'd5,
        A_TXLVL = 3'd6,
        A_RXLVL = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/fti_thresh_regs.sv
// Holds the transmit and receive threshold registers.
// Assumes writes arrive as one-cycle strobes; writes are dropped while en_i is high.
module fti_thresh_regs #(
    parameter int TH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            wr_tx_i,
    input  logic            wr_rx_i,
    input  logic [TH_W-1:0] wdata_i,
    output logic [TH_W-1:0] tx_thr_o,
    output logic [TH_W-1:0] rx_thr_o
);
    logic [1:0]      sel;
    logic [TH_W-1:0] thr_q [2];

    assign sel = {wr_rx_i, wr_tx_i};

    for (genvar g = 0; g < 2; g++) begin : g_thr
        // Capture a threshold only while the controller is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[g] <= '0;
            else if (sel[g] && !en_i)
                thr_q[g] <= wdata_i;
        end

        p_thr_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
            en_i |=> $stable(thr_q[g]));
    end

    assign tx_thr_o = thr_q[0];
    assign rx_thr_o = thr_q[1];
endmodule

// File: rtl/fti_sticky_bank.sv
// A bank of sticky event flags, each set by an event and cleared by a request.
// Assumes a set and a clear in the same cycle leave the flag set.
module fti_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Set on an event, drop on a clear without a new event, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (set_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g])
                flag_q[g] <= 1'b0;
        end

        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
        p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/fti_level_cmp.sv
// Compares FIFO occupancies against the programmed thresholds.
// Assumes levels are wide enough to hold the full depth.
module fti_level_cmp #(
    parameter int LVL_W = 6,
    parameter int TH_W  = 5
) (
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [TH_W-1:0]  tx_thr_i,
    input  logic [TH_W-1:0]  rx_thr_i,
    output logic             tx_want_o,
    output logic             rx_want_o
);
    logic [LVL_W-1:0] tx_thr_ext;
    logic [LVL_W-1:0] rx_thr_ext;

    // Widen thresholds to level width before comparing.
    always_comb begin
        tx_thr_ext = LVL_W'(tx_thr_i);
        rx_thr_ext = LVL_W'(rx_thr_i);
        tx_want_o  = (tx_level_i <= tx_thr_ext);
        rx_want_o  = (rx_level_i >  rx_thr_ext);
    end
endmodule

// File: rtl/fifo_thresh_irq.sv
// FIFO threshold interrupt controller: level and sticky interrupt sources,
// mask, clear register and status word behind a simple register port.
// Assumes DEPTH is 32 or 64 and DW covers both the 7-bit vector and a level.
module fifo_thresh_irq
    import fti_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int LVL_W = $clog2(DEPTH) + 1,
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             tx_push,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             ss_inactive,
    input  logic             eng_busy,
    input  logic             slv_tx_busy,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    output logic [5:0]       status
);
    logic [TH_W-1:0]     tx_thr, rx_thr;
    logic                tx_want, rx_want;
    logic [N_STICKY-1:0] stk_set, stk_clr, stk_flag;
    logic [IRQ_W-1:0]    raw, masked, mask_q;
    logic                clr_wr, clr_all;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata;

    fti_thresh_regs #(.TH_W(TH_W)) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl_en),
        .wr_tx_i  (reg_wr && (reg_addr == A_TXTHR)),
        .wr_rx_i  (reg_wr && (reg_addr == A_RXTHR)),
        .wdata_i  (reg_wdata[TH_W-1:0]),
        .tx_thr_o (tx_thr),
        .rx_thr_o (rx_thr)
    );

    fti_level_cmp #(.LVL_W(LVL_W), .TH_W(TH_W)) u_cmp (
        .tx_level_i (tx_level),
        .rx_level_i (rx_level),
        .tx_thr_i   (tx_thr),
        .rx_thr_i   (rx_thr),
        .tx_want_o  (tx_want),
        .rx_want_o  (rx_want)
    );

    // Route events and clear requests to the sticky bank (order: txo, rxu, rxo, ssi).
    always_comb begin
        clr_wr  = reg_wr && (reg_addr == A_CLR);
        clr_all = clr_wr && reg_wdata[CB_ALL];
        stk_set = {ss_inactive, rx_push && rx_full, rx_pop && rx_empty, tx_push && tx_full};
        stk_clr = {clr_all,
                   clr_all || (clr_wr && reg_wdata[CB_RXO]),
                   clr_all || (clr_wr && reg_wdata[CB_RXU]),
                   clr_all || (clr_wr && reg_wdata[CB_TXO])};
    end

    fti_sticky_bank #(.N(N_STICKY)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set),
        .clr_i  (stk_clr),
        .flag_o (stk_flag)
    );

    // Hold the interrupt mask written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && (reg_addr == A_MASK))
            mask_q <= reg_wdata[IRQ_W-1:0];
    end

    // Assemble raw and masked vectors and the interrupt line.
    always_comb begin
        raw         = '0;
        raw[IB_TXE] = tx_want;
        raw[IB_TXO] = stk_flag[0];
        raw[IB_RXU] = stk_flag[1];
        raw[IB_RXO] = stk_flag[2];
        raw[IB_RXF] = rx_want;
        raw[IB_SSI] = stk_flag[3];
        masked      = raw & mask_q;
        irq         = |masked;
    end

    // Collect the polling status word.
    assign status = {slv_tx_busy, rx_full, rx_empty, tx_empty, tx_full, eng_busy};

    // Select read data for the current address.
    always_comb begin
        unique case (reg_addr)
            A_TXTHR: reg_rdata = DW'(tx_thr);
            A_RXTHR: reg_rdata = DW'(rx_thr);
            A_MASK:  reg_rdata = DW'(mask_q);
            A_RAW:   reg_rdata = DW'(raw);
            A_MSKD:  reg_rdata = DW'(masked);
            A_TXLVL: reg_rdata = DW'(tx_level);
            A_RXLVL: reg_rdata = DW'(rx_level);
            default: reg_rdata = '0;
        endcase
    end

    p_no_irq_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    p_txe_empty_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> raw[IB_TXE]);
    p_rxf_empty_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !raw[IB_RXF]);
    p_txo_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> raw[IB_TXO]);
endmodule

// File: tb/fifo_thresh_irq_test.sv
module fifo_thresh_irq_test;
    localparam int DEPTH = 32;
    localparam int DW    = 8;
    localparam int LVL_W = 6;

    logic clk = 1'b0, rst_n = 1'b0, ctrl_en = 1'b0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic tx_push = 0, tx_full = 0, tx_empty = 0, rx_push = 0, rx_pop = 0;
    logic rx_full = 0, rx_empty = 0, ss_inactive = 0, eng_busy = 0, slv_tx_busy = 0;
    logic reg_wr = 0;
    logic [2:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic irq;
    logic [5:0] status;

    fifo_thresh_irq #(.DEPTH(DEPTH), .DW(DW)) uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        int         cyc;
        int         kind;   // 0 read data, 1 irq, 2 status
        logic [7:0] val;
        string      tag;
    } item_t;

    item_t q[$];
    int cyc = 0, n_chk = 0, n_bad = 0;
    bit done = 0;

    int m_txthr = 0, m_rxthr = 0;
    logic [6:0] m_mask = '0, m_stk = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle away from the edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = reg_rdata;
                1: act = {7'd0, irq};
                default: act = {2'd0, status};
            endcase
            n_chk++;
            if (act !== it.val) begin
                n_bad++;
                $display("FIFO-check FAIL %s: actual %h expected %h", it.tag, act, it.val);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [7:0] v, input string tag);
        reg_addr = a;
        q.push_back('{cyc, kind, v, tag});
        step();
    endtask

    function automatic logic [6:0] exp_raw();
        logic [6:0] r;
        r = m_stk;
        r[0] = (int'(tx_level) <= m_txthr);
        r[4] = (int'(rx_level) >= m_rxthr + 1);
        return r;
    endfunction

    task automatic chk_raw(input string tag);
        logic [6:0] r;
        r = exp_raw();
        expect_item(0, 3'd3, {1'b0, r}, tag);
        expect_item(0, 3'd4, {1'b0, r & m_mask}, tag);
        expect_item(1, 3'd0, {7'd0, |(r & m_mask)}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("watchdog FAIL: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        expect_item(0, 3'd0, 8'h00, "R1 tx threshold");
        expect_item(0, 3'd1, 8'h00, "R1 rx threshold");
        expect_item(0, 3'd2, 8'h00, "R1 mask");
        chk_raw("R1 raw after reset");

        // R8: thresholds programmable while disabled
        wr(3'd0, 8'd4); m_txthr = 4;
        wr(3'd1, 8'd7); m_rxthr = 7;
        expect_item(0, 3'd0, 8'd4, "R8 tx threshold write");
        expect_item(0, 3'd1, 8'd7, "R8 rx threshold write");

        // R2: transmit level on and past threshold
        tx_level = 6'd4; chk_raw("R2 level equal threshold");
        tx_level = 6'd5; chk_raw("R2 level above threshold");
        tx_level = 6'd0; chk_raw("R2 level zero");
        tx_level = 6'd9;

        // R3: receive level on and past threshold
        rx_level = 6'd7;  chk_raw("R3 level equal threshold");
        rx_level = 6'd8;  chk_raw("R3 level threshold plus one");
        rx_level = 6'd32; chk_raw("R3 full depth");
        rx_level = 6'd2;

        // R7: mask and irq
        wr(3'd2, 8'h11); m_mask = 7'h11;
        chk_raw("R7 mask no source");
        tx_level = 6'd3; chk_raw("R7 tx source masked in");
        tx_level = 6'd9;
        rx_level = 6'd20; chk_raw("R7 rx source masked in");
        rx_level = 6'd2;
        wr(3'd2, 8'h7f); m_mask = 7'h7f;

        // R4: sticky events
        tx_push = 1; step(); tx_push = 0;
        chk_raw("R4 push without full ignored");
        tx_push = 1; tx_full = 1; step(); tx_push = 0; tx_full = 0; m_stk[1] = 1;
        chk_raw("R4 tx overflow held");
        rx_pop = 1; rx_empty = 1; step(); rx_pop = 0; rx_empty = 0; m_stk[2] = 1;
        chk_raw("R4 rx underflow held");
        rx_push = 1; rx_full = 1; step(); rx_push = 0; rx_full = 0; m_stk[3] = 1;
        chk_raw("R4 rx overflow held");
        ss_inactive = 1; step(); ss_inactive = 0; m_stk[6] = 1;
        chk_raw("R4 slave select inactive held");

        // R5: per-event clears
        wr(3'd5, 8'h02); m_stk[2] = 0; chk_raw("R5 clear rx underflow");
        wr(3'd5, 8'h08); m_stk[1] = 0; chk_raw("R5 clear tx overflow");

        // R6: clear and new event in the same cycle
        rx_push = 1; rx_full = 1;
        wr(3'd5, 8'h04);
        rx_push = 0; rx_full = 0;
        chk_raw("R6 event beats clear");

        // R5: clear all
        tx_push = 1; tx_full = 1; step(); tx_push = 0; tx_full = 0; m_stk[1] = 1;
        wr(3'd5, 8'h01); m_stk = '0;
        chk_raw("R5 clear all sticky");
        m_mask = 7'h00; wr(3'd2, 8'h00);
        expect_item(1, 3'd0, 8'h00, "R7 irq off with zero mask");

        // R8: writes ignored while enabled
        ctrl_en = 1;
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd3);
        expect_item(0, 3'd0, 8'd4, "R8 tx threshold locked");
        expect_item(0, 3'd1, 8'd7, "R8 rx threshold locked");
        tx_level = 6'd6; chk_raw("R8 locked threshold still applied");
        ctrl_en = 0;
        wr(3'd0, 8'd9); m_txthr = 9;
        expect_item(0, 3'd0, 8'd9, "R8 unlocked write");

        // R9: status word
        eng_busy = 1; tx_full = 1;
        expect_item(2, 3'd0, 8'h03, "R9 busy and tx full");
        eng_busy = 0; tx_full = 0; rx_empty = 1; slv_tx_busy = 1;
        expect_item(2, 3'd0, 8'h28, "R9 rx empty and slave tx busy");
        tx_empty = 1; rx_empty = 0; slv_tx_busy = 0; rx_full = 1;
        expect_item(2, 3'd0, 8'h14, "R9 tx empty and rx full");
        tx_empty = 0; rx_full = 0;

        // R10: level registers
        tx_level = 6'd17; rx_level = 6'd32;
        expect_item(0, 3'd6, 8'd17, "R10 tx level");
        expect_item(0, 3'd7, 8'd32, "R10 rx level");

        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule